// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the clock line waveform of an I2C master. Two 9-bit period counts set how long the clock is held low and how long it is left released. A prescale input picks one or two input clock cycles per count step. The block drives a single open-drain pull request (`scl_pull`, high means pull the line low) and watches the line through `scl_in`.

The low phase is timed from the cycle in which the block starts pulling. The high phase is timed only after the line has been sampled high, so a slow rise or a slave that stretches the clock makes the high phase longer instead of shorter. Two single-cycle strobes serve a byte engine. `shift_tick` marks the last cycle of the low phase, where the next data bit is launched. `sample_tick` marks the first counted cycle of the high phase, where the data line is sampled.

The low eight bits of each count come from their own inputs. The ninth bit of each count comes from a shared extension byte. A parameter removes the extension, which caps both counts at 255. Generating START and STOP and working out the period values are left to the surrounding logic.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `enable` is low, and after reset, `scl_pull`, `sample_tick` and `shift_tick` are all 0 from the next cycle on, and both counters are cleared.
- R2: Once enabled, the block pulls the line for exactly Leff*P consecutive cycles, starting in the cycle after `enable` is first seen high. This timing does not depend on `scl_in`. Leff is the effective low count and P is the prescale factor.
- R3: After the line is released, `sample_tick` rises exactly S+2 cycles later, where S is the number of cycles `scl_in` stays low after release. The 2 cycles are one input register stage plus one detect cycle. `scl_pull` then reasserts exactly Heff*P cycles after the start of the `sample_tick` cycle, counting that cycle.
- R4: `shift_tick` is high for exactly one cycle per low phase, in its last pulled cycle.
- R5: A count value of 0, for either the low or the high period, behaves as a count of 1.
- R6: `slow_step` = 0 gives P = 1 input cycle per count step. `slow_step` = 1 gives P = 2.
- R7: With the extension enabled, bit 8 of the low count is `span_ext[7]` and bit 8 of the high count is `span_ext[6]`. Bits 5..0 of `span_ext` have no effect.
- R8: With `EXT_EN` = 0, `span_ext` is ignored entirely, so each count is at most 255.
- R9: Dropping `enable` in the middle of a phase releases the line in the next cycle. A later enable starts again with a full low phase.
- R10: `sample_tick` and `shift_tick` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low releases the line and clears the counters |
| slow_step | input | 1 | 1: two input cycles per count step; 0: one |
| low_span | input | 8 | Low period count, bits 7..0 |
| high_span | input | 8 | High period count, bits 7..0 |
| span_ext | input | 8 | Bit 7: low count bit 8; bit 6: high count bit 8 |
| scl_in | input | 1 | Sensed clock line level |
| scl_pull | output | 1 | 1 requests pulling the clock line low |
| sample_tick | output | 1 | First cycle of the counted high phase |
| shift_tick | output | 1 | Last cycle of the low phase |

## Verification
A wrong phase or counter value shows up at the ports within a single clock period. It appears as a pulled run or a released run of the wrong length, or as a strobe that is missing, doubled or misplaced inside its run. A high counter that starts before the line is seen high shortens the released interval by exactly the stretch length, so the bench holds `scl_in` low for a controlled number of cycles and measures the gap to `sample_tick`. Runs that use the ninth bit stretch a phase to 256 steps or more, which exposes a truncated or misrouted extension bit within that same period.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter bit EXT_EN      = 1'b1,
  parameter int BASE_W      = 8,
  parameter int EXT_LOW_BIT = 7,
  parameter int EXT_HI_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              slow_step,
  input  logic [BASE_W-1:0] low_span,
  input  logic [BASE_W-1:0] high_span,
  input  logic [BASE_W-1:0] span_ext,
  input  logic              scl_in,
  output logic              scl_pull,
  output logic              sample_tick,
  output logic              shift_tick
);
  localparam int CNT_W = BASE_W + 1;

  typedef enum logic [1:0] {PH_OFF, PH_LOW, PH_WAIT, PH_HIGH} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             pre;
  logic             scl_s;
  logic             low_top, high_top;
  logic [CNT_W-1:0] low_full, high_full, low_eff, high_eff;
  logic             step_end, low_last, high_last;

  generate
    if (EXT_EN) begin : g_ext
      assign low_top  = span_ext[EXT_LOW_BIT];
      assign high_top = span_ext[EXT_HI_BIT];
    end else begin : g_noext
      assign low_top  = 1'b0;
      assign high_top = 1'b0;
    end
  endgenerate

  assign low_full  = {low_top, low_span};
  assign high_full = {high_top, high_span};
  assign low_eff   = (low_full == '0)  ? CNT_W'(1) : low_full;
  assign high_eff  = (high_full == '0) ? CNT_W'(1) : high_full;

  assign step_end  = (pre == slow_step);
  assign low_last  = (phase == PH_LOW)  && step_end && (cnt == low_eff - 1'b1);
  assign high_last = (phase == PH_HIGH) && step_end && (cnt == high_eff - 1'b1);

  assign scl_pull    = (phase == PH_LOW);
  assign shift_tick  = low_last;
  assign sample_tick = (phase == PH_HIGH) && (cnt == '0) && !pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_s <= 1'b0;
    else        scl_s <= scl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      cnt   <= '0;
      pre   <= 1'b0;
    end else if (!enable) begin
      phase <= PH_OFF;
      cnt   <= '0;
      pre   <= 1'b0;
    end else begin
      unique case (phase)
        PH_OFF: begin
          phase <= PH_LOW;
          cnt   <= '0;
          pre   <= 1'b0;
        end
        PH_WAIT: begin
          cnt <= '0;
          pre <= 1'b0;
          if (scl_s) phase <= PH_HIGH;
        end
        default: begin
          if (low_last || high_last) begin
            phase <= low_last ? PH_WAIT : PH_LOW;
            cnt   <= '0;
            pre   <= 1'b0;
          end else if (step_end) begin
            pre <= 1'b0;
            cnt <= cnt + 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_pull,
  input logic sample_tick,
  input logic shift_tick
);
  // R1: disabled generator is quiet from the next cycle
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull && !sample_tick && !shift_tick));

  // R2: a pulled phase only ends through its final cycle or a disable
  a_r2_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !shift_tick && enable) |=> scl_pull);

  // R4: the shift strobe sits in the last pulled cycle
  a_r4_shift_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    shift_tick |-> scl_pull);
  a_r4_shift_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    shift_tick |=> !scl_pull);

  // R3: sampling happens only after the line was seen high, never on release
  a_r3_sample_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (!scl_pull && $past(scl_in)));
  a_r3_no_instant_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> !sample_tick);

  // R10: strobes are mutually exclusive
  a_r10_ticks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_tick && shift_tick));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
  .scl_pull(scl_pull), .sample_tick(sample_tick), .shift_tick(shift_tick)
);

// File: tb/test_i2c_scl_timer.sv
module test_i2c_scl_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic slow_step = 1'b0;
  logic [7:0] low_span = '0, high_span = '0, span_ext = '0;
  logic stretch = 1'b0;
  logic sel_narrow = 1'b0;
  logic pull_w, samp_w, shift_w, pull_n, samp_n, shift_n;
  logic scl_w, scl_n;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  assign scl_w = !pull_w && !stretch;
  assign scl_n = !pull_n && !stretch;

  i2c_scl_timer i_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slow_step(slow_step),
    .low_span(low_span), .high_span(high_span), .span_ext(span_ext),
    .scl_in(scl_w), .scl_pull(pull_w), .sample_tick(samp_w), .shift_tick(shift_w));

  i2c_scl_timer #(.EXT_EN(1'b0)) i_i2c_scl_timer_narrow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slow_step(slow_step),
    .low_span(low_span), .high_span(high_span), .span_ext(span_ext),
    .scl_in(scl_n), .scl_pull(pull_n), .sample_tick(samp_n), .shift_tick(shift_n));

  wire cur_pull  = sel_narrow ? pull_n  : pull_w;
  wire cur_samp  = sel_narrow ? samp_n  : samp_w;
  wire cur_shift = sel_narrow ? shift_n : shift_w;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_count(input logic [7:0] base, input bit top);
    int v;
    v = {23'd0, top, base};
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_case(input logic [7:0] lv, input logic [7:0] hv, input logic [7:0] ev,
                          input bit sl, input int st, input bit nar, input string tag);
    int n, sh, shcnt, g, h, el, eh, p;
    p  = sl ? 2 : 1;
    el = eff_count(lv, nar ? 1'b0 : ev[7]) * p;
    eh = eff_count(hv, nar ? 1'b0 : ev[6]) * p;
    @(negedge clk);
    enable = 1'b0; low_span = lv; high_span = hv; span_ext = ev;
    slow_step = sl; sel_narrow = nar; stretch = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    while (!cur_pull) @(negedge clk);
    n = 0; sh = -1; shcnt = 0;
    while (cur_pull) begin
      if (cur_shift) begin sh = n; shcnt++; end
      n++;
      @(negedge clk);
    end
    chk(n == el, {tag, " R2 low length"}, n, el);
    chk(sh == n - 1 && shcnt == 1, {tag, " R4 shift position"}, sh, n - 1);
    g = 0;
    if (st > 0) stretch = 1'b1;
    while (!cur_samp) begin
      g++;
      @(negedge clk);
      if (g == st) stretch = 1'b0;
    end
    stretch = 1'b0;
    chk(g == st + 2, {tag, " R3 release to sample"}, g, st + 2);
    h = 0;
    while (!cur_pull) begin
      h++;
      @(negedge clk);
    end
    chk(h == eh, {tag, " R3 high length"}, h, eh);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!pull_w && !samp_w && !shift_w, "R1 reset quiet", pull_w, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pull_w && !pull_n, "R1 disabled released", pull_w, 0);

    run_case(8'd5, 8'd4, 8'h00, 1'b0, 0, 1'b0, "basic");
    run_case(8'd0, 8'd0, 8'h00, 1'b0, 0, 1'b0, "R5 zero");
    run_case(8'd0, 8'd0, 8'h00, 1'b1, 0, 1'b0, "R5 zero R6 slow");
    run_case(8'd7, 8'd3, 8'h00, 1'b1, 2, 1'b0, "R6 slow stretch");
    run_case(8'd3, 8'd2, 8'h00, 1'b0, 3, 1'b0, "R3 stretch");
    run_case(8'd0, 8'd1, 8'hC0, 1'b0, 0, 1'b0, "R7 ext both");
    run_case(8'd2, 8'd3, 8'h3F, 1'b0, 1, 1'b0, "R7 low bits ignored");
    run_case(8'd0, 8'd1, 8'hC0, 1'b0, 0, 1'b1, "R8 narrow ext ignored");
    run_case(8'hFF, 8'hFF, 8'hFF, 1'b0, 0, 1'b1, "R8 narrow max");

    // R9: disable in mid low phase, then restart
    sel_narrow = 1'b0;
    @(negedge clk);
    enable = 1'b0; low_span = 8'd10; high_span = 8'd4; span_ext = 8'h00; slow_step = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(pull_w, "R9 low in progress", pull_w, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!pull_w && !samp_w && !shift_w, "R9 R1 release on disable", pull_w, 0);
    repeat (2) @(negedge clk);
    chk(!pull_w, "R1 stays released", pull_w, 0);
    run_case(8'd10, 8'd4, 8'h00, 1'b0, 0, 1'b0, "R9 restart full");

    for (int i = 0; i < 30; i++) begin
      logic [7:0] lv, hv, ev;
      lv = 8'($urandom_range(0, 30));
      hv = 8'($urandom_range(0, 30));
      ev = 8'($urandom);
      run_case(lv, hv, ev, 1'($urandom), int'($urandom_range(0, 3)), 1'($urandom), "rand");
    end

    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!pull_w && !pull_n, "R1 final release", pull_w, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule